// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional test is true. A caller presents a 6-bit predicate code, the current 32-bit floating-point status word and a one-cycle evaluate strobe. One clock later the block returns the truth value of the predicate, a flag that marks the code as illegal, and the status word as the test leaves it. The branch, decrement-and-branch, set and trap instructions that consume this result lie outside the block.

The condition-code nibble of the status word sits in bits 27..24: negative (N, bit 27), zero (Z, bit 26), infinity (bit 25, never used in a test) and not-a-number (NaN, bit 24). The exception byte occupies bits 15..8, and its top bit, bit 15, is the unordered-test exception flag. Predicate bit 4 selects the variant of a test that signals on an unordered operand. Predicate bit 3 selects the inverted test: the code is XORed with 15 to reach a base test, and that base test's result is complemented. The eight base tests are: 0 never, 1 equal, 2 greater, 3 greater-or-equal, 4 less, 5 less-or-equal, 6 greater-or-less, 7 ordered.

Top module: `fpc_pred_eval`

## Requirements
- R1: While reset is asserted and until the first strobe, valid_o, cond_o and illegal_o are 0 and status_o is all zeros.
- R2: valid_o is high in exactly the cycle after the one in which eval_i is sampled high. cond_o, illegal_o and status_o change only at that clock edge and hold their values at all other times.
- R3: A predicate code of 32 or above gives illegal_o=1 and cond_o=0, and status_o is the input status word unchanged. Codes 0 to 31 give illegal_o=0.
- R4: Base test 0 is always false. Base test 1 is true when Z (bit 26) is set.
- R5: Base test 2 is true when NaN, Z and N are all clear. Base test 4 is true when N is set and both NaN and Z are clear.
- R6: Base test 3 is true when Z is set, or when NaN and N are both clear. Base test 5 is true when Z is set, or when N is set and NaN is clear.
- R7: Base test 6 is true when NaN and Z are both clear. Base test 7 is true when NaN is clear.
- R8: A legal code with bit 3 set returns the complement of base test (code[3:0] XOR 15).
- R9: For any legal code, setting bit 4 does not change cond_o.
- R10: For a legal code, status_o bits 14..8 are 0, whatever the input.
- R11: For a legal code, status_o bit 15 is 1 exactly when predicate bit 4 is set and input bit 24 (NaN) is set.
- R12: For a legal code, every status_o bit outside bits 15..8 equals the same bit of the input status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluate strobe; inputs are sampled when it is high |
| pred_i | input | 6 | Predicate code |
| status_i | input | 32 | Current floating-point status word |
| valid_o | output | 1 | Result present, one cycle after the strobe |
| cond_o | output | 1 | Predicate truth value |
| illegal_o | output | 1 | Predicate code out of range |
| status_o | output | 32 | Status word after evaluation |

## Verification
The assertions check the parts of the output contract that hold on every cycle, whatever the code: valid_o follows the strobe by one cycle, the outputs hold between results, an illegal result is never true, the low seven exception bits of a legal result are clear, and the unordered flag appears only when the NaN bit has passed through. The truth table can only be shown by the bench's scenarios. These cover each base test against all sixteen condition nibbles, the inversion and signalling halves of the code space, illegal codes with busy status words, and inputs that change while no strobe is present.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    BASE_NEVER = 3'd0,
    BASE_EQ    = 3'd1,
    BASE_GT    = 3'd2,
    BASE_GE    = 3'd3,
    BASE_LT    = 3'd4,
    BASE_LE    = 3'd5,
    BASE_GL    = 3'd6,
    BASE_ORD   = 3'd7
  } base_e;

  typedef struct packed {
    logic  illegal;
    logic  signal_nan;
    logic  invert;
    base_e base;
  } pred_fields_t;

  typedef struct packed {
    logic neg;
    logic zero;
    logic nan;
  } cc_t;

endpackage

// File: rtl/fpc_pred_split.sv
module fpc_pred_split
  import fpc_pkg::*;
#(
  parameter int PRED_W = 6
) (
  input  logic [PRED_W-1:0] pred_i,
  output pred_fields_t      fields_o
);
  localparam int LEGAL_W = 5;
  localparam int INV_BIT = 3;
  localparam int SIG_BIT = 4;

  logic [2:0] low3;

  always_comb begin
    low3                = pred_i[2:0] ^ {3{pred_i[INV_BIT]}};
    fields_o.illegal    = |pred_i[PRED_W-1:LEGAL_W];
    fields_o.signal_nan = pred_i[SIG_BIT];
    fields_o.invert     = pred_i[INV_BIT];
    fields_o.base       = base_e'(low3);
  end
endmodule

// File: rtl/fpc_base_eval.sv
module fpc_base_eval
  import fpc_pkg::*;
(
  input  base_e base_i,
  input  cc_t   cc_i,
  output logic  hit_o
);
  always_comb begin
    unique case (base_i)
      BASE_NEVER: hit_o = 1'b0;
      BASE_EQ:    hit_o = cc_i.zero;
      BASE_GT:    hit_o = ~(cc_i.nan | cc_i.zero | cc_i.neg);
      BASE_GE:    hit_o = cc_i.zero | ~(cc_i.nan | cc_i.neg);
      BASE_LT:    hit_o = cc_i.neg & ~cc_i.nan & ~cc_i.zero;
      BASE_LE:    hit_o = cc_i.zero | (cc_i.neg & ~cc_i.nan);
      BASE_GL:    hit_o = ~(cc_i.nan | cc_i.zero);
      BASE_ORD:   hit_o = ~cc_i.nan;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpc_status_upd.sv
module fpc_status_upd #(
  parameter int STATUS_W = 32,
  parameter int EXC_LSB  = 8,
  parameter int EXC_W    = 8
) (
  input  logic [STATUS_W-1:0] status_i,
  input  logic                set_flag_i,
  output logic [STATUS_W-1:0] status_o
);
  localparam int FLAG_BIT = EXC_LSB + EXC_W - 1;
  localparam logic [STATUS_W-1:0] EXC_MASK =
    {{(STATUS_W-EXC_W){1'b0}}, {EXC_W{1'b1}}} << EXC_LSB;
  localparam logic [STATUS_W-1:0] FLAG_MASK =
    {{(STATUS_W-1){1'b0}}, 1'b1} << FLAG_BIT;

  always_comb begin
    status_o = (status_i & ~EXC_MASK) | (set_flag_i ? FLAG_MASK : '0);
  end
endmodule

// File: rtl/fpc_pred_eval.sv
module fpc_pred_eval
  import fpc_pkg::*;
#(
  parameter int PRED_W   = 6,
  parameter int STATUS_W = 32,
  parameter int CC_LSB   = 24,
  parameter int EXC_LSB  = 8,
  parameter int EXC_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eval_i,
  input  logic [PRED_W-1:0]   pred_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic                valid_o,
  output logic                cond_o,
  output logic                illegal_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam int NAN_BIT  = CC_LSB;
  localparam int ZERO_BIT = CC_LSB + 2;
  localparam int NEG_BIT  = CC_LSB + 3;
  localparam int FLAG_BIT = EXC_LSB + EXC_W - 1;

  pred_fields_t        fields;
  cc_t                 cc;
  logic                base_hit;
  logic [STATUS_W-1:0] status_upd;

  logic                valid_q, cond_q, illegal_q;
  logic [STATUS_W-1:0] status_q;
  logic                valid_d, cond_d, illegal_d;
  logic [STATUS_W-1:0] status_d;
  logic                cond_nx;
  logic [STATUS_W-1:0] status_nx;

  assign cc.neg  = status_i[NEG_BIT];
  assign cc.zero = status_i[ZERO_BIT];
  assign cc.nan  = status_i[NAN_BIT];

  fpc_pred_split #(.PRED_W(PRED_W)) u_split (
    .pred_i   (pred_i),
    .fields_o (fields)
  );

  fpc_base_eval u_base (
    .base_i (fields.base),
    .cc_i   (cc),
    .hit_o  (base_hit)
  );

  fpc_status_upd #(
    .STATUS_W (STATUS_W),
    .EXC_LSB  (EXC_LSB),
    .EXC_W    (EXC_W)
  ) u_stat (
    .status_i   (status_i),
    .set_flag_i (fields.signal_nan & cc.nan),
    .status_o   (status_upd)
  );

  // Next-state logic; eval_i is the clock enable of the result registers.
  always_comb begin
    cond_nx   = fields.illegal ? 1'b0 : (base_hit ^ fields.invert);
    status_nx = fields.illegal ? status_i : status_upd;
    valid_d   = eval_i;
    cond_d    = eval_i ? cond_nx        : cond_q;
    illegal_d = eval_i ? fields.illegal : illegal_q;
    status_d  = eval_i ? status_nx      : status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      cond_q    <= 1'b0;
      illegal_q <= 1'b0;
      status_q  <= '0;
    end else begin
      valid_q   <= valid_d;
      cond_q    <= cond_d;
      illegal_q <= illegal_d;
      status_q  <= status_d;
    end
  end

  assign valid_o   = valid_q;
  assign cond_o    = cond_q;
  assign illegal_o = illegal_q;
  assign status_o  = status_q;

  // R2
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> valid_o);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> !valid_o);
  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(cond_o) && $stable(illegal_o) && $stable(status_o)));
  // R3
  illegal_never_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !cond_o);
  // R10
  exc_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !illegal_o) |-> (status_o[FLAG_BIT-1:EXC_LSB] == '0));
  // R11
  flag_needs_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !illegal_o && status_o[FLAG_BIT]) |-> status_o[NAN_BIT]);
endmodule

// File: tb/sim_fpc_pred_eval.sv
module sim_fpc_pred_eval;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        eval_i;
  logic [5:0]  pred_i;
  logic [31:0] status_i;
  logic        valid_o, cond_o, illegal_o;
  logic [31:0] status_o;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  fpc_pred_eval u0 (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .pred_i(pred_i),
    .status_i(status_i), .valid_o(valid_o), .cond_o(cond_o),
    .illegal_o(illegal_o), .status_o(status_o)
  );

  function automatic bit base_truth(int b, bit n, bit z, bit nan);
    case (b)
      0: return 1'b0;
      1: return z;
      2: return !nan && !z && !n;
      3: return z || (!nan && !n);
      4: return n && !nan && !z;
      5: return z || (n && !nan);
      6: return !nan && !z;
      default: return !nan;
    endcase
  endfunction

  function automatic bit ref_cond(int code, logic [31:0] st);
    int c;
    if (code >= 32) return 1'b0;
    c = code % 16;
    if (c >= 8) return !base_truth(15 - c, st[27], st[26], st[24]);
    return base_truth(c, st[27], st[26], st[24]);
  endfunction

  function automatic logic [31:0] ref_status(int code, logic [31:0] st);
    logic [31:0] r;
    if (code >= 32) return st;
    r = st;
    for (int k = 8; k < 16; k++) r[k] = 1'b0;
    if ((code / 16) % 2 == 1 && st[24]) r[15] = 1'b1;
    return r;
  endfunction

  function automatic string cond_tag(int code);
    int b;
    if (code >= 32) return "R3";
    if ((code / 16) % 2 == 1) return "R9";
    if ((code / 8) % 2 == 1) return "R8";
    b = code % 8;
    if (b <= 1) return "R4";
    if (b == 2 || b == 4) return "R5";
    if (b == 3 || b == 5) return "R6";
    return "R7";
  endfunction

  // Behavioural reference registers
  logic        m_valid, m_cond, m_ill;
  logic [31:0] m_status;
  int          m_code;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0; m_cond <= 0; m_ill <= 0; m_status <= 0; m_code <= 0;
    end else begin
      m_valid <= eval_i;
      if (eval_i) begin
        m_code   <= int'(pred_i);
        m_cond   <= ref_cond(int'(pred_i), status_i);
        m_ill    <= (pred_i >= 6'd32);
        m_status <= ref_status(int'(pred_i), status_i);
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h (code %0d)", tag, what, act, exp, m_code);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string st_tag;
      chk("R2", "valid", 32'(valid_o), 32'(m_valid));
      chk(cond_tag(m_code), "cond", 32'(cond_o), 32'(m_cond));
      chk("R3", "illegal", 32'(illegal_o), 32'(m_ill));
      if (m_code >= 32) st_tag = "R3";
      else if (status_o[15] !== m_status[15]) st_tag = "R11";
      else if (status_o[15:8] !== m_status[15:8]) st_tag = "R10";
      else st_tag = "R12";
      chk(st_tag, "status", status_o, m_status);
    end
  end

  initial begin
    int seed;
    rst_n = 0; eval_i = 0; pred_i = 0; status_i = 0;
    seed = 32'h1357_9bdf;
    repeat (3) @(negedge clk);
    status_i = 32'hffff_ffff; pred_i = 6'd17; eval_i = 1;
    @(negedge clk);
    // R1: outputs remain in reset state while reset is held
    total++;
    if (valid_o !== 0 || cond_o !== 0 || illegal_o !== 0 || status_o !== 0) begin
      fails++;
      $display("FAIL R1 reset: actual=%b%b%b %h expected=000 00000000",
               valid_o, cond_o, illegal_o, status_o);
    end
    eval_i = 0;
    rst_n = 1;
    @(negedge clk);
    for (int t = 0; t < 1024; t++) begin
      seed = seed * 1103515245 + 12345;
      pred_i   = 6'(t / 16);
      status_i = 32'(seed);
      status_i[27:24] = 4'(t % 16);
      if (t % 5 == 0) status_i[15:8] = 8'hff;
      eval_i = 1;
      @(negedge clk);
      if (t % 3 == 0) begin
        // inputs move while no strobe: outputs must hold (R2)
        eval_i = 0;
        pred_i = ~pred_i;
        status_i = ~status_i;
        @(negedge clk);
      end
    end
    eval_i = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule